// File: doc/BRIEF.md
# Two-Port Repeater Core

This block is the control core of a two-slice repeater on a shared segment. Slice 0 faces the network and slice 1 faces the local host. Whatever arrives on one slice is sent out on the other as it arrives, one nibble per clock. Nothing is stored first. Both slices are assumed to run at the same rate, and the core never converts between rates. Each slice brings in a nibble stream with a data-valid flag, a receive-error flag, a carrier-sense input and a collision input. Each slice takes out a nibble stream with a transmit-enable and a transmit-error flag.

The core picks the slice that owns the segment. If that choice is contested, it jams every slice. A fragment that ends too short is stretched to the minimum length. After every burst the core holds a quiet gap. Three single-cycle event pulses go to a partition monitor: collision start, collision end and burst end.

All outputs are registered. A nibble received in one cycle appears on the outputs one clock edge later. The reset input is asynchronous and active low, and its release is synchronised inside the block through two flops.

Top module: `duo_repeater`

## Requirements
- R1: While reset is held, and through its synchronised release, every tx_en, tx_er and tx_d bit is 0 and no event pulse is raised.
- R2: From idle, when only slice 0 shows carrier and no collision input is set, slice 1 transmits each slice-0 nibble one clock later (tx_d bits 7:4, tx_en bit 1). Slice 0 does not transmit.
- R3: The same forwarding works from slice 1 (rx_d bits 7:4) to slice 0 (tx_d bits 3:0).
- R4: A collision input raised on a slice makes both slices transmit the jam nibble 0x5 from the next clock. ev_col_start pulses for exactly one cycle, on the first jam cycle.
- R5: Carrier on both slices at once, whether it starts together or arrives while one slice is forwarding, is treated as a collision with the same jam and the same start pulse.
- R6: A burst whose carrier ends after fewer than MIN_NIB (24) transmitted nibbles is padded with 0x5 nibbles (tx_er low) on the destination slice until MIN_NIB nibbles have been sent.
- R7: A burst of MIN_NIB or more nibbles is forwarded at exactly its own length, with no padding.
- R8: Once the source's rx_er is seen high, that nibble and every later forwarded nibble of the burst carry tx_er. Earlier nibbles carry none.
- R9: ev_pkt_end pulses for one cycle on the first cycle in which all tx_en bits are low after a burst.
- R10: For GAP_NIB (24) cycles after the burst-end cycle, carrier and data on either slice are ignored and no slice transmits.
- R11: After a collision, jam continues on both slices while any collision input or carrier remains, and for at least MIN_NIB nibbles in total. On leaving jam, ev_col_end pulses together with ev_pkt_end.
- R12: While the source has carrier but its rx_dv is low, the forwarded nibble is 0x5 regardless of rx_d, with tx_er low.

## Ports
| Port | Direction | Width | Description |
|------|-----------|-------|-------------|
| clk | input | 1 | Nibble clock shared by both slices |
| rst_n | input | 1 | Asynchronous active-low reset |
| rx_dv | input | 2 | Receive data valid, bit p for slice p |
| rx_er | input | 2 | Receive error, bit p for slice p |
| rx_d | input | 2*NIB_W | Received nibbles, slice p at bits p*NIB_W +: NIB_W |
| crs | input | 2 | Carrier sense per slice |
| col | input | 2 | Collision input per slice |
| tx_en | output | 2 | Transmit enable per slice |
| tx_er | output | 2 | Transmit error per slice |
| tx_d | output | 2*NIB_W | Transmitted nibbles, same packing as rx_d |
| ev_col_start | output | 1 | One-cycle pulse on the first collision jam cycle |
| ev_col_end | output | 1 | One-cycle pulse when collision jam ends |
| ev_pkt_end | output | 1 | One-cycle pulse when a burst ends |

## Verification
The bench builds the core with its defaults: NIB_W of 4, MIN_NIB of 24, GAP_NIB of 24 and a jam nibble of 0x5. With a 24-nibble minimum, the bench can reach bursts of 23, 24 and 30 nibbles. These cover a single pad nibble, the exact boundary, and a length-counter saturation. Collisions are placed both at the very first nibble and deep into a burst. With a 24-cycle gap, there is room to drive carrier on both slices across the whole quiet window and show that it is dropped.

// File: rtl/rptr_pkg.sv
`timescale 1ns/1ps
package rptr_pkg;
  typedef enum logic [1:0] {ST_IDLE, ST_DATA, ST_JAM, ST_WAIT} rpt_state_e;
  typedef enum logic [1:0] {TXM_OFF, TXM_FWD, TXM_JAM} tx_mode_e;
endpackage

// File: rtl/rptr_ctrl.sv
`timescale 1ns/1ps
module rptr_ctrl import rptr_pkg::*; #(
  parameter int              NIB_W   = 4,
  parameter int              MIN_NIB = 24,
  parameter int              GAP_NIB = 24,
  parameter logic [NIB_W-1:0] JAM_NIB = 4'h5
) (
  input  logic               clk,
  input  logic               rst_n,
  input  logic [1:0]         rx_dv_i,
  input  logic [1:0]         rx_er_i,
  input  logic [2*NIB_W-1:0] rx_d_i,
  input  logic [1:0]         crs_i,
  input  logic [1:0]         col_i,
  output tx_mode_e [1:0]     mode_o,
  output logic [NIB_W-1:0]   fwd_d_o,
  output logic               fwd_er_o,
  output logic               col_enter_o,
  output logic               col_exit_o,
  output logic               pkt_done_o
);
  localparam int CNT_W = $clog2(MIN_NIB + 1);
  localparam int GAP_W = $clog2(GAP_NIB + 1);
  localparam logic [CNT_W-1:0] CNT_MIN = CNT_W'(MIN_NIB);
  localparam logic [CNT_W-1:0] CNT_ONE = CNT_W'(1);
  localparam logic [GAP_W-1:0] GAP_LD  = GAP_W'(GAP_NIB);
  localparam logic [GAP_W-1:0] GAP_ONE = GAP_W'(1);

  rpt_state_e       state_q, state_d;
  logic             src_q, src_d;
  logic [CNT_W-1:0] cnt_q, cnt_d, cnt_inc;
  logic [GAP_W-1:0] gap_q, gap_d;
  logic             err_q, err_d;
  logic             colf_q, colf_d;
  logic [1:0]       jmask_q, jmask_d;
  logic             col_any, src_now, dst, stay;
  logic [NIB_W-1:0] fwd_nib;

  assign col_any = (|col_i) | (&crs_i);
  assign src_now = (state_q == ST_IDLE) ? crs_i[1] : src_q;
  assign dst     = ~src_now;
  assign cnt_inc = (cnt_q == CNT_MIN) ? cnt_q : cnt_q + CNT_ONE;
  assign fwd_nib = !rx_dv_i[src_now] ? JAM_NIB :
                   (src_now ? rx_d_i[2*NIB_W-1:NIB_W] : rx_d_i[NIB_W-1:0]);
  assign stay    = col_any | (colf_q & (|crs_i)) | (cnt_q < CNT_MIN);

  always_comb begin
    state_d = state_q;  src_d = src_q;  cnt_d = cnt_q;  gap_d = gap_q;
    err_d = err_q;  colf_d = colf_q;  jmask_d = jmask_q;
    for (int p = 0; p < 2; p++) mode_o[p] = TXM_OFF;
    fwd_d_o = '0;  fwd_er_o = 1'b0;
    col_enter_o = 1'b0;  col_exit_o = 1'b0;  pkt_done_o = 1'b0;
    case (state_q)
      ST_IDLE: begin
        cnt_d = '0;  err_d = 1'b0;  colf_d = 1'b0;  jmask_d = '0;
        if (col_any) begin
          state_d = ST_JAM;  colf_d = 1'b1;  jmask_d = 2'b11;
          cnt_d = CNT_ONE;   col_enter_o = 1'b1;
          for (int p = 0; p < 2; p++) mode_o[p] = TXM_JAM;
        end else if (|crs_i) begin
          state_d = ST_DATA;  src_d = src_now;  cnt_d = CNT_ONE;
          mode_o[dst] = TXM_FWD;
          fwd_d_o  = fwd_nib;
          fwd_er_o = rx_er_i[src_now];
          err_d    = rx_er_i[src_now];
        end
      end
      ST_DATA: begin
        if (col_any) begin
          state_d = ST_JAM;  colf_d = 1'b1;  jmask_d = 2'b11;
          cnt_d = cnt_inc;   col_enter_o = 1'b1;
          for (int p = 0; p < 2; p++) mode_o[p] = TXM_JAM;
        end else if (crs_i[src_q]) begin
          mode_o[dst] = TXM_FWD;
          fwd_d_o  = fwd_nib;
          fwd_er_o = err_q | rx_er_i[src_q];
          err_d    = err_q | rx_er_i[src_q];
          cnt_d    = cnt_inc;
        end else if (cnt_q < CNT_MIN) begin
          state_d = ST_JAM;
          jmask_d = src_q ? 2'b01 : 2'b10;
          mode_o[dst] = TXM_JAM;
          cnt_d = cnt_inc;
        end else begin
          state_d = ST_WAIT;  gap_d = GAP_LD;  pkt_done_o = 1'b1;
        end
      end
      ST_JAM: begin
        if (stay) begin
          if (col_any && !colf_q) begin
            colf_d = 1'b1;  jmask_d = 2'b11;  col_enter_o = 1'b1;
          end
          cnt_d = cnt_inc;
          for (int p = 0; p < 2; p++) if (jmask_d[p]) mode_o[p] = TXM_JAM;
        end else begin
          state_d = ST_WAIT;  gap_d = GAP_LD;
          pkt_done_o = 1'b1;  col_exit_o = colf_q;
        end
      end
      ST_WAIT: begin
        gap_d = gap_q - GAP_ONE;
        if (gap_q == GAP_ONE) state_d = ST_IDLE;
      end
      default: state_d = ST_IDLE;
    endcase
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      state_q <= ST_IDLE;  src_q <= 1'b0;  cnt_q <= '0;  gap_q <= '0;
      err_q <= 1'b0;  colf_q <= 1'b0;  jmask_q <= '0;
    end else begin
      state_q <= state_d;  src_q <= src_d;  cnt_q <= cnt_d;  gap_q <= gap_d;
      err_q <= err_d;  colf_q <= colf_d;  jmask_q <= jmask_d;
    end
  end

  // R10: nothing is offered for transmission while the quiet gap runs
  a_r10_gap_silent: assert property (@(posedge clk) disable iff (!rst_n)
    (state_q == ST_WAIT) |-> (mode_o[0] == TXM_OFF && mode_o[1] == TXM_OFF));
endmodule

// File: rtl/rptr_slice.sv
`timescale 1ns/1ps
module rptr_slice import rptr_pkg::*; #(
  parameter int               NIB_W   = 4,
  parameter logic [NIB_W-1:0] JAM_NIB = 4'h5
) (
  input  logic             clk,
  input  logic             rst_n,
  input  tx_mode_e         mode_i,
  input  logic [NIB_W-1:0] fwd_d_i,
  input  logic             fwd_er_i,
  output logic             tx_en_o,
  output logic             tx_er_o,
  output logic [NIB_W-1:0] tx_d_o
);
  logic             en_d, er_d;
  logic [NIB_W-1:0] d_d;

  always_comb begin
    en_d = 1'b0;  er_d = 1'b0;  d_d = '0;
    case (mode_i)
      TXM_FWD: begin en_d = 1'b1; er_d = fwd_er_i; d_d = fwd_d_i; end
      TXM_JAM: begin en_d = 1'b1; d_d = JAM_NIB; end
      default: ;
    endcase
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      tx_en_o <= 1'b0;  tx_er_o <= 1'b0;  tx_d_o <= '0;
    end else begin
      tx_en_o <= en_d;  tx_er_o <= er_d;  tx_d_o <= d_d;
    end
  end

  // R8: an error flag is only ever sent alongside an enabled nibble
  a_r8_er_with_en: assert property (@(posedge clk) disable iff (!rst_n)
    tx_er_o |-> tx_en_o);
endmodule

// File: rtl/rptr_events.sv
`timescale 1ns/1ps
module rptr_events (
  input  logic clk,
  input  logic rst_n,
  input  logic col_enter_i,
  input  logic col_exit_i,
  input  logic pkt_done_i,
  output logic col_start_o,
  output logic col_end_o,
  output logic pkt_end_o
);
  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      col_start_o <= 1'b0;  col_end_o <= 1'b0;  pkt_end_o <= 1'b0;
    end else begin
      col_start_o <= col_enter_i;
      col_end_o   <= col_exit_i;
      pkt_end_o   <= pkt_done_i;
    end
  end

  // R4: collision start is a single-cycle pulse
  a_r4_start_single: assert property (@(posedge clk) disable iff (!rst_n)
    col_start_o |=> !col_start_o);
  // R11: collision end is always reported together with a burst end
  a_r11_end_with_pkt: assert property (@(posedge clk) disable iff (!rst_n)
    col_end_o |-> pkt_end_o);
endmodule

// File: rtl/duo_repeater.sv
`timescale 1ns/1ps
module duo_repeater import rptr_pkg::*; #(
  parameter int               NIB_W   = 4,
  parameter int               MIN_NIB = 24,
  parameter int               GAP_NIB = 24,
  parameter logic [NIB_W-1:0] JAM_NIB = 4'h5
) (
  input  logic               clk,
  input  logic               rst_n,
  input  logic [1:0]         rx_dv,
  input  logic [1:0]         rx_er,
  input  logic [2*NIB_W-1:0] rx_d,
  input  logic [1:0]         crs,
  input  logic [1:0]         col,
  output logic [1:0]         tx_en,
  output logic [1:0]         tx_er,
  output logic [2*NIB_W-1:0] tx_d,
  output logic               ev_col_start,
  output logic               ev_col_end,
  output logic               ev_pkt_end
);
  localparam int NPORT = 2;
  localparam int CNT_W = $clog2(MIN_NIB + 1);

  logic [1:0]       rs_q;
  logic             rst_n_s;
  tx_mode_e [1:0]   mode;
  logic [NIB_W-1:0] fwd_d;
  logic             fwd_er, col_enter, col_exit, pkt_done;

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) rs_q <= 2'b00;
    else        rs_q <= {rs_q[0], 1'b1};
  end
  assign rst_n_s = rs_q[1];

  rptr_ctrl #(.NIB_W(NIB_W), .MIN_NIB(MIN_NIB), .GAP_NIB(GAP_NIB), .JAM_NIB(JAM_NIB)) u_ctrl (
    .clk(clk), .rst_n(rst_n_s), .rx_dv_i(rx_dv), .rx_er_i(rx_er), .rx_d_i(rx_d),
    .crs_i(crs), .col_i(col), .mode_o(mode), .fwd_d_o(fwd_d), .fwd_er_o(fwd_er),
    .col_enter_o(col_enter), .col_exit_o(col_exit), .pkt_done_o(pkt_done));

  for (genvar p = 0; p < NPORT; p++) begin : g_slice
    rptr_slice #(.NIB_W(NIB_W), .JAM_NIB(JAM_NIB)) u_slice (
      .clk(clk), .rst_n(rst_n_s), .mode_i(mode[p]), .fwd_d_i(fwd_d), .fwd_er_i(fwd_er),
      .tx_en_o(tx_en[p]), .tx_er_o(tx_er[p]), .tx_d_o(tx_d[p*NIB_W +: NIB_W]));
  end

  rptr_events u_ev (
    .clk(clk), .rst_n(rst_n_s), .col_enter_i(col_enter), .col_exit_i(col_exit),
    .pkt_done_i(pkt_done), .col_start_o(ev_col_start), .col_end_o(ev_col_end),
    .pkt_end_o(ev_pkt_end));

  // checker support: length of the current transmit burst
  logic [CNT_W-1:0] run_q;
  always_ff @(posedge clk or negedge rst_n_s) begin
    if (!rst_n_s)    run_q <= '0;
    else if (|tx_en) run_q <= (run_q == CNT_W'(MIN_NIB)) ? run_q : run_q + CNT_W'(1);
    else             run_q <= '0;
  end

  // R6: no burst leaves the core shorter than the minimum
  a_r6_min_burst: assert property (@(posedge clk) disable iff (!rst_n_s)
    $fell(|tx_en) |-> (run_q == CNT_W'(MIN_NIB)));
  // R4: both slices transmitting at once only ever carry the jam nibble
  a_r4_dual_is_jam: assert property (@(posedge clk) disable iff (!rst_n_s)
    (&tx_en) |-> (tx_d == {JAM_NIB, JAM_NIB} && tx_er == 2'b00));
  // R9: burst end coincides with all slices silent
  a_r9_end_idle: assert property (@(posedge clk) disable iff (!rst_n_s)
    ev_pkt_end |-> (tx_en == 2'b00));
endmodule

// File: tb/duo_repeater_tb.sv
`timescale 1ns/1ps
module duo_repeater_tb;
  localparam int MIN = 24;
  localparam int GAP = 24;

  logic clk = 1'b0;
  always #2.5 clk = ~clk;

  logic       rst_n;
  logic [1:0] rx_dv, rx_er, crs, col;
  logic [7:0] rx_d;
  logic [1:0] tx_en, tx_er;
  logic [7:0] tx_d;
  logic       ev_col_start, ev_col_end, ev_pkt_end;

  duo_repeater #(.NIB_W(4), .MIN_NIB(MIN), .GAP_NIB(GAP), .JAM_NIB(4'h5)) u_dut (
    .clk(clk), .rst_n(rst_n), .rx_dv(rx_dv), .rx_er(rx_er), .rx_d(rx_d),
    .crs(crs), .col(col), .tx_en(tx_en), .tx_er(tx_er), .tx_d(tx_d),
    .ev_col_start(ev_col_start), .ev_col_end(ev_col_end), .ev_pkt_end(ev_pkt_end));

  typedef struct {
    logic [1:0] en;
    logic [1:0] er;
    logic [7:0] d;
    logic [2:0] ev;   // {col_start, col_end, pkt_end}
    string      tag;
  } exp_t;

  exp_t q[$];
  int   n_vec = 0;
  int   n_bad = 0;
  bit   done  = 1'b0;

  task automatic chk(input exp_t x);
    logic [2:0] ev;
    ev = {ev_col_start, ev_col_end, ev_pkt_end};
    n_vec++;
    if (tx_en !== x.en || tx_er !== x.er || tx_d !== x.d || ev !== x.ev) begin
      n_bad++;
      $display("FAIL %s: en=%b er=%b d=%h ev=%b expected en=%b er=%b d=%h ev=%b",
               x.tag, tx_en, tx_er, tx_d, ev, x.en, x.er, x.d, x.ev);
    end
  endtask

  task automatic summary();
    if (!done) begin
      done = 1'b1;
      $display("== %0d vectors applied, %0d miscompares ==", n_vec, n_bad);
      $finish;
    end
  endtask

  // monitor: one expected item per clock, compared just after the edge
  initial begin
    forever begin
      @(posedge clk);
      #1;
      if (q.size() > 0) chk(q.pop_front());
    end
  end

  // driver: apply inputs for one cycle, queue the output expected after the next edge
  task automatic step(input logic [1:0] dv, input logic [1:0] er, input logic [7:0] d,
                      input logic [1:0] cs, input logic [1:0] cl,
                      input logic [1:0] e_en, input logic [1:0] e_er, input logic [7:0] e_d,
                      input logic [2:0] e_ev, input string tag);
    exp_t x;
    @(negedge clk);
    rx_dv = dv;  rx_er = er;  rx_d = d;  crs = cs;  col = cl;
    x.en = e_en;  x.er = e_er;  x.d = e_d;  x.ev = e_ev;  x.tag = tag;
    q.push_back(x);
  endtask

  // R10: carrier on both slices during the gap must be ignored
  task automatic quiet_gap();
    for (int i = 0; i < GAP; i++)
      step(2'b11, 2'b00, 8'h3C, 2'b11, 2'b00, 2'b00, 2'b00, 8'h00, 3'b000, "R10");
    step(2'b00, 2'b00, 8'h00, 2'b00, 2'b00, 2'b00, 2'b00, 8'h00, 3'b000, "R10");
  endtask

  task automatic frame(input int src, input int pre, input int len, input int err_at,
                       input string tag);
    int dst;
    dst = 1 - src;
    for (int i = 0; i < len; i++) begin
      logic [3:0] ni, no;
      logic [1:0] dv, er, ee;
      string      t;
      ni = (i < pre) ? 4'hA : 4'((i * 5 + src * 3 + 1) & 15);
      no = (i < pre) ? 4'h5 : ni;
      dv = (i < pre) ? 2'b00 : 2'(1 << src);
      er = (i == err_at) ? 2'(1 << src) : 2'b00;
      ee = (err_at >= 0 && i >= err_at) ? 2'(1 << dst) : 2'b00;
      t  = (i < pre) ? "R12" : ((ee != 2'b00) ? "R8" : tag);
      step(dv, er, 8'(ni) << (4 * src), 2'(1 << src), 2'b00,
           2'(1 << dst), ee, 8'(no) << (4 * dst), 3'b000, t);
    end
    for (int i = len; i < MIN; i++)
      step(2'b00, 2'b00, 8'h00, 2'b00, 2'b00, 2'(1 << dst), 2'b00,
           8'h05 << (4 * dst), 3'b000, "R6");
    step(2'b00, 2'b00, 8'h00, 2'b00, 2'b00, 2'b00, 2'b00, 8'h00, 3'b001, "R9");
    quiet_gap();
  endtask

  // fwd: nibbles forwarded first; ncol: collision cycles; both: cause is dual carrier;
  // hold: source carrier kept until this cycle index
  task automatic coll(input int src, input int fwd, input int ncol, input bit both,
                      input int hold, input string tag);
    int  dst;
    bit  fin;
    dst = 1 - src;
    fin = 1'b0;
    for (int s = 0; s < 200 && !fin; s++) begin
      if (s < fwd) begin
        logic [3:0] ni;
        ni = 4'((s * 7 + 2) & 15);
        step(2'(1 << src), 2'b00, 8'(ni) << (4 * src), 2'(1 << src), 2'b00,
             2'(1 << dst), 2'b00, 8'(ni) << (4 * dst), 3'b000, (src == 0) ? "R2" : "R3");
      end else if (s < fwd + ncol) begin
        if (both)
          step(2'b11, 2'b00, 8'h77, 2'b11, 2'b00, 2'b11, 2'b00, 8'h55,
               (s == fwd) ? 3'b100 : 3'b000, tag);
        else
          step(2'(1 << src), 2'b00, 8'h99, 2'(1 << src), 2'(1 << src), 2'b11, 2'b00, 8'h55,
               (s == fwd) ? 3'b100 : 3'b000, tag);
      end else if (s < hold) begin
        step(2'(1 << src), 2'b00, 8'h66, 2'(1 << src), 2'b00, 2'b11, 2'b00, 8'h55,
             3'b000, "R11");
      end else if (s < MIN) begin
        step(2'b00, 2'b00, 8'h00, 2'b00, 2'b00, 2'b11, 2'b00, 8'h55, 3'b000, "R11");
      end else begin
        step(2'b00, 2'b00, 8'h00, 2'b00, 2'b00, 2'b00, 2'b00, 8'h00, 3'b011, "R11");
        fin = 1'b1;
      end
    end
    quiet_gap();
  endtask

  initial begin
    exp_t z;
    rst_n = 1'b0;
    rx_dv = '0;  rx_er = '0;  rx_d = '0;  crs = '0;  col = '0;
    repeat (3) @(negedge clk);
    z.en = '0;  z.er = '0;  z.d = '0;  z.ev = '0;  z.tag = "R1";
    chk(z);
    rst_n = 1'b1;
    for (int i = 0; i < 4; i++)
      step(2'b00, 2'b00, 8'h00, 2'b00, 2'b00, 2'b00, 2'b00, 8'h00, 3'b000, "R1");

    frame(0, 2, 10, -1, "R2");     // short, with regenerated preamble, padded
    frame(1, 0, 8, -1, "R3");      // host to network, padded
    frame(0, 0, 30, -1, "R7");     // long, counter saturates
    frame(0, 0, 24, -1, "R7");     // exactly the minimum
    frame(0, 0, 23, -1, "R6");     // one pad nibble
    frame(1, 3, 30, 12, "R3");     // error mid-burst
    coll(0, 5, 3, 1'b0, 8, "R4");  // collision input mid-burst
    coll(0, 0, 3, 1'b0, 3, "R4");  // collision input from idle
    coll(0, 0, 3, 1'b1, 3, "R5");  // dual carrier from idle
    coll(1, 4, 2, 1'b1, 27, "R5"); // second carrier mid-burst, long tail

    repeat (3) @(negedge clk);
    summary();
  end

  initial begin
    repeat (200000) @(posedge clk);
    n_bad++;
    $display("FAIL watchdog: run did not complete, expected completion");
    summary();
  end
endmodule